// File: doc/BRIEF.md
# PTP Event Timestamp Capture Queue

This block records when PTP event messages pass a network port and holds those records until a CPU collects them. A packet-decode front end raises a start-of-message strobe at the moment the message begins. The block samples the current time (48-bit seconds and 32-bit nanoseconds) on that strobe. Later, when the decoder knows the message type, sequence ID and a 12-bit checksum digest, it raises a descriptor-valid strobe. The block then decides whether to keep the record.

A 16-bit enable mask, which software can write, selects the message types that are kept. Each kept record is 128 bits wide and goes into a 16-entry first-in first-out queue. Software reads a record as four 32-bit words through a small register port. Reading the least significant word acknowledges the record and removes it from the queue. A status word reports how many entries are queued, whether the queue is empty, and a sticky flag that is set when a record was lost because the queue was full. One instance serves the transmit direction and one serves the receive direction; each has its own address range.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset the queue is empty (status reads 0x0000_0100), the overflow flag is clear, the enable mask reads 0x0000_000F, and the read data output is 0.
- R2: The time stored in a record is the value of the time inputs on the cycle the start strobe was high. Changes to the time inputs after that cycle do not affect the record.
- R3: A descriptor of message type n is queued only if bit n of the enable mask is 1. A descriptor whose mask bit is 0 leaves the queue count and contents unchanged.
- R4: Register address 0 holds the enable mask in bits [15:0]. Bits [31:16] are ignored on write and read as 0.
- R5: A record is read as four words. Address 2 returns {16'h0000, seconds[47:32]}. Address 3 returns seconds[31:0]. Address 4 returns nanoseconds. Address 5 returns {type[3:0], checksum[11:0], sequence ID[15:0]}. Together these form the 128-bit record {16 zero bits, seconds, nanoseconds, type, checksum, sequence}.
- R6: Reading addresses 2 to 4 does not remove the entry. A read of address 5 removes the head entry. Entries leave in the order in which they arrived.
- R7: The status word at address 1 holds the entry count in bits [4:0], the empty flag in bit 8 and the overflow flag in bit 9. All other bits read 0.
- R8: While 16 entries are queued, a new accepted descriptor is dropped, the overflow flag is set, and the stored entries stay unchanged.
- R9: The overflow flag stays set until software writes address 1 with bit 0 equal to 1. If a drop and a clear happen in the same cycle, the flag ends up set.
- R10: A descriptor strobe that has no start strobe pending since the last descriptor creates no entry. A read of address 5 while the queue is empty returns 0 and removes nothing.
- R11: Read data appears on the output one clock after the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start-of-message strobe; the time is sampled on this cycle |
| meta_valid_i | input | 1 | Descriptor-valid strobe for the pending message |
| msg_type_i | input | 4 | PTP message type |
| seq_id_i | input | 16 | PTP sequence ID |
| csum_i | input | 12 | Checksum digest of the message |
| sec_i | input | 48 | Current time, seconds |
| nsec_i | input | 32 | Current time, nanoseconds |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |

## Verification
On every cycle, the assertions check four things:
- The entry count never exceeds the queue depth.
- A push happens only for a type whose mask bit was set.
- An accepted descriptor with no simultaneous pop raises the count by one, and an overflowing push leaves a full queue full.
- The overflow flag is sticky, and the read data holds when no read is issued.

Only the bench scenarios can show the rest: that the record holds the time from the start strobe rather than the later time, the exact bit placement in the four words, first-in first-out order after an overflow, and the results of empty reads and of orphan descriptors.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int SEC_W  = 48;
  localparam int NSEC_W = 32;
  localparam int TYPE_W = 4;
  localparam int CSUM_W = 12;
  localparam int SEQ_W  = 16;
  localparam int REC_W  = 128;
  localparam int PAD_W  = REC_W - SEC_W - NSEC_W - TYPE_W - CSUM_W - SEQ_W;
  localparam int WORD_W = 32;
  localparam int NTYPES = 1 << TYPE_W;
  localparam int AW     = 3;

  localparam logic [AW-1:0] A_MASK   = 3'd0;
  localparam logic [AW-1:0] A_STATUS = 3'd1;
  localparam logic [AW-1:0] A_W3     = 3'd2;
  localparam logic [AW-1:0] A_W2     = 3'd3;
  localparam logic [AW-1:0] A_W1     = 3'd4;
  localparam logic [AW-1:0] A_W0     = 3'd5;

  localparam logic [NTYPES-1:0] MASK_RST = 16'h000F;

  function automatic logic [REC_W-1:0] pack_rec(
    input logic [SEC_W-1:0]  s,
    input logic [NSEC_W-1:0] ns,
    input logic [TYPE_W-1:0] t,
    input logic [CSUM_W-1:0] c,
    input logic [SEQ_W-1:0]  q);
    return {{PAD_W{1'b0}}, s, ns, t, c, q};
  endfunction
endpackage

// File: rtl/tsc_stamp_filter.sv
module tsc_stamp_filter
  import tsc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sof_i,
  input  logic                  meta_valid_i,
  input  logic [TYPE_W-1:0]     type_i,
  input  logic [SEQ_W-1:0]      seq_i,
  input  logic [CSUM_W-1:0]     csum_i,
  input  logic [SEC_W-1:0]      sec_i,
  input  logic [NSEC_W-1:0]     nsec_i,
  input  logic [NTYPES-1:0]     mask_i,
  output logic                  push_o,
  output logic [REC_W-1:0]      rec_o
);
  logic [SEC_W-1:0]  sec_q;
  logic [NSEC_W-1:0] nsec_q;
  logic              pending_q;
  logic              accept;

  assign accept = meta_valid_i && pending_q && mask_i[type_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q     <= '0;
      nsec_q    <= '0;
      pending_q <= 1'b0;
      push_o    <= 1'b0;
      rec_o     <= '0;
    end else begin
      if (sof_i) begin
        sec_q  <= sec_i;
        nsec_q <= nsec_i;
      end
      if (sof_i)
        pending_q <= 1'b1;
      else if (meta_valid_i)
        pending_q <= 1'b0;
      push_o <= accept;
      if (accept)
        rec_o <= pack_rec(sec_q, nsec_q, type_i, csum_i, seq_i);
    end
  end

  // R3
  push_mask_chk: assert property (@(posedge clk) disable iff (rst)
    push_o |-> $past(meta_valid_i && mask_i[type_i]));

endmodule

// File: rtl/tsc_queue.sv
module tsc_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 128
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push_i,
  input  logic [W-1:0]              data_i,
  input  logic                      pop_i,
  output logic [W-1:0]              head_o,
  output logic [$clog2(DEPTH):0]    count_o,
  output logic                      empty_o,
  output logic                      drop_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, do_push, do_pop;

  assign full    = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign drop_o  = push_i && full;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push)
      mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push)
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)
        rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count_o <= CW'(DEPTH));

  // R3
  push_grows_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && count_o < CW'(DEPTH) && !pop_i) |=> count_o == $past(count_o) + 1'b1);

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && count_o == CW'(DEPTH) && !pop_i) |=> count_o == CW'(DEPTH));

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && count_o == '0 && !push_i) |=> count_o == '0);

endmodule

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [REC_W-1:0]    head_i,
  input  logic [CW-1:0]       count_i,
  input  logic                empty_i,
  input  logic                drop_i,
  output logic [NTYPES-1:0]   mask_o,
  output logic                pop_o,
  output logic [WORD_W-1:0]   rdata_o
);
  localparam int NW = REC_W / WORD_W;

  logic              ovf_q;
  logic              ovf_clr;
  logic [WORD_W-1:0] words [NW];
  logic [WORD_W-1:0] status;
  logic [WORD_W-1:0] rd_mux;

  for (genvar g = 0; g < NW; g++) begin : g_split
    assign words[g] = empty_i ? '0 : head_i[g*WORD_W +: WORD_W];
  end

  assign ovf_clr = wr_i && addr_i == A_STATUS && wdata_i[0];
  assign pop_o   = rd_i && addr_i == A_W0;
  assign status  = {{(WORD_W-10){1'b0}}, ovf_q, empty_i, {(8-CW){1'b0}}, count_i};

  always_comb begin
    case (addr_i)
      A_MASK:   rd_mux = {{(WORD_W-NTYPES){1'b0}}, mask_o};
      A_STATUS: rd_mux = status;
      A_W3:     rd_mux = words[3];
      A_W2:     rd_mux = words[2];
      A_W1:     rd_mux = words[1];
      A_W0:     rd_mux = words[0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o  <= MASK_RST;
      ovf_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (wr_i && addr_i == A_MASK)
        mask_o <= wdata_i[NTYPES-1:0];
      if (drop_i)
        ovf_q <= 1'b1;
      else if (ovf_clr)
        ovf_q <= 1'b0;
      if (rd_i)
        rdata_o <= rd_mux;
    end
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clr) |=> ovf_q);

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    drop_i |=> ovf_q);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import tsc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sof_i,
  input  logic         meta_valid_i,
  input  logic [3:0]   msg_type_i,
  input  logic [15:0]  seq_id_i,
  input  logic [11:0]  csum_i,
  input  logic [47:0]  sec_i,
  input  logic [31:0]  nsec_i,
  input  logic         reg_wr_i,
  input  logic         reg_rd_i,
  input  logic [2:0]   reg_addr_i,
  input  logic [31:0]  reg_wdata_i,
  output logic [31:0]  reg_rdata_o
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic              push, pop, empty, drop;
  logic [REC_W-1:0]  rec, head;
  logic [CW-1:0]     count;
  logic [NTYPES-1:0] mask;

  tsc_stamp_filter u_filter (
    .clk          (clk),
    .rst          (rst),
    .sof_i        (sof_i),
    .meta_valid_i (meta_valid_i),
    .type_i       (msg_type_i),
    .seq_i        (seq_id_i),
    .csum_i       (csum_i),
    .sec_i        (sec_i),
    .nsec_i       (nsec_i),
    .mask_i       (mask),
    .push_o       (push),
    .rec_o        (rec)
  );

  tsc_queue #(.DEPTH(DEPTH), .W(REC_W)) u_queue (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push),
    .data_i  (rec),
    .pop_i   (pop),
    .head_o  (head),
    .count_o (count),
    .empty_o (empty),
    .drop_o  (drop)
  );

  tsc_regs #(.CW(CW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .head_i  (head),
    .count_i (count),
    .empty_i (empty),
    .drop_i  (drop),
    .mask_o  (mask),
    .pop_o   (pop),
    .rdata_o (reg_rdata_o)
  );

endmodule

// File: tb/tb_ts_capture_unit.sv
module tb_ts_capture_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sof_i = 0, meta_valid_i = 0;
  logic [3:0]  msg_type_i = 0;
  logic [15:0] seq_id_i = 0;
  logic [11:0] csum_i = 0;
  logic [47:0] sec_i = 0;
  logic [31:0] nsec_i = 0;
  logic        reg_wr_i = 0, reg_rd_i = 0;
  logic [2:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0;
  logic [31:0] reg_rdata_o;

  int tests = 0, fails = 0;

  // vector: {type, seq, csum, sec, nsec}
  localparam logic [111:0] VEC [NV] = '{
    {4'd0,  16'h1001, 12'hA01, 48'h0000_1234_5678, 32'h0000_0010},
    {4'd1,  16'h1002, 12'hA02, 48'h8000_0000_0001, 32'h3B9A_C9FF},
    {4'd2,  16'h1003, 12'hA03, 48'h0000_0000_0003, 32'h0000_0030},
    {4'd3,  16'hFFFF, 12'hFFF, 48'hFFFF_FFFF_FFFF, 32'hFFFF_FFFF},
    {4'd8,  16'h1005, 12'hA05, 48'h0000_0000_0005, 32'h0000_0050},
    {4'd9,  16'h0000, 12'h000, 48'h0000_0000_0000, 32'h0000_0000},
    {4'd11, 16'h1007, 12'hA07, 48'h0000_0000_0007, 32'h0000_0070},
    {4'd12, 16'h1008, 12'hA08, 48'h0000_0000_0008, 32'h0000_0080}
  };
  localparam logic [15:0] TBL_MASK = 16'h020B;

  ts_capture_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_i = 1; reg_addr_i = a;
    @(negedge clk);
    reg_rd_i = 0;
    d = reg_rdata_o;
  endtask

  task automatic send(input logic [3:0] t, input logic [15:0] q, input logic [11:0] c,
                      input logic [47:0] s, input logic [31:0] ns);
    @(negedge clk);
    sec_i = s; nsec_i = ns; sof_i = 1;
    @(negedge clk);
    sof_i = 0; sec_i = ~s; nsec_i = ~ns;
    meta_valid_i = 1; msg_type_i = t; seq_id_i = q; csum_i = c;
    @(negedge clk);
    meta_valid_i = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_rec(output logic [127:0] r);
    logic [31:0] w3, w2, w1, w0;
    reg_read(3'd2, w3);
    reg_read(3'd3, w2);
    reg_read(3'd4, w1);
    reg_read(3'd5, w0);
    r = {w3, w2, w1, w0};
  endtask

  initial begin
    logic [31:0]  d;
    logic [127:0] r;
    logic [127:0] expq [16];
    int           nexp;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", reg_rdata_o, 32'h0);
    reg_read(3'd1, d); chk("R1 status", d, 32'h0000_0100);
    reg_read(3'd0, d); chk("R1 mask", d, 32'h0000_000F);

    // R4 mask write, upper bits ignored
    reg_write(3'd0, {16'hFFFF, TBL_MASK});
    reg_read(3'd0, d); chk("R4 mask readback", d, {16'h0, TBL_MASK});

    // Table walk: R2 R3 R5
    nexp = 0;
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][111:108], VEC[i][107:92], VEC[i][91:80], VEC[i][79:32], VEC[i][31:0]);
      if (TBL_MASK[VEC[i][111:108]]) begin
        expq[nexp] = {16'h0, VEC[i][79:32], VEC[i][31:0], VEC[i][111:108], VEC[i][91:80], VEC[i][107:92]};
        nexp++;
      end
    end
    reg_read(3'd1, d); chk("R3 R7 count after table", d, 32'(nexp));
    for (int i = 0; i < nexp; i++) begin
      reg_read(3'd2, d); chk("R5 word addr2", d, expq[i][127:96]);
      reg_read(3'd3, d); chk("R2 R5 seconds low", d, expq[i][95:64]);
      reg_read(3'd4, d); chk("R2 R5 nanoseconds", d, expq[i][63:32]);
      reg_read(3'd1, d); chk("R6 no pop on upper words", d, 32'(nexp - i));
      reg_read(3'd5, d); chk("R5 R6 word addr5", d, expq[i][31:0]);
    end
    reg_read(3'd1, d); chk("R6 drained", d, 32'h0000_0100);

    // R10 descriptor without start strobe
    @(negedge clk);
    meta_valid_i = 1; msg_type_i = 4'd0;
    @(negedge clk);
    meta_valid_i = 0;
    repeat (2) @(negedge clk);
    reg_read(3'd1, d); chk("R10 orphan descriptor", d, 32'h0000_0100);
    reg_read(3'd5, d); chk("R10 empty read data", d, 32'h0);
    reg_read(3'd1, d); chk("R10 empty read no change", d, 32'h0000_0100);

    // R8 overflow
    reg_write(3'd0, 32'h0000_FFFF);
    for (int i = 0; i < 17; i++)
      send(4'(i), 16'(i), 12'h0C0, 48'(i * 7), 32'(i * 3));
    reg_read(3'd1, d); chk("R8 R7 full with overflow", d, 32'h0000_0210);
    for (int i = 0; i < 16; i++) begin
      read_rec(r);
      chk("R8 entry kept", r[31:0], {4'(i), 12'h0C0, 16'(i)});
    end
    // R9 sticky overflow
    reg_read(3'd1, d); chk("R9 sticky after drain", d, 32'h0000_0300);
    reg_write(3'd1, 32'h0000_0000);
    reg_read(3'd1, d); chk("R9 clear needs bit0", d, 32'h0000_0300);
    reg_write(3'd1, 32'h0000_0001);
    reg_read(3'd1, d); chk("R9 cleared", d, 32'h0000_0100);

    // R11 read latency and hold
    reg_read(3'd0, d);
    @(negedge clk);
    reg_rd_i = 1; reg_addr_i = 3'd1;
    #1;
    chk("R11 before edge", reg_rdata_o, 32'h0000_FFFF);
    @(negedge clk);
    reg_rd_i = 0;
    chk("R11 after edge", reg_rdata_o, 32'h0000_0100);
    repeat (3) @(negedge clk);
    chk("R11 hold", reg_rdata_o, 32'h0000_0100);

    // R3 masked type leaves queue unchanged
    reg_write(3'd0, 32'h0000_0001);
    send(4'd5, 16'h5555, 12'h555, 48'h5, 32'h5);
    reg_read(3'd1, d); chk("R3 masked type dropped", d, 32'h0000_0100);

    // R1 reset mid-run
    send(4'd0, 16'h7777, 12'h777, 48'h7, 32'h7);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    reg_read(3'd1, d); chk("R1 status after reset", d, 32'h0000_0100);
    reg_read(3'd0, d); chk("R1 mask after reset", d, 32'h0000_000F);

    finish_run();
  end
endmodule